// File: doc/BRIEF.md
# I2C Serial Clock Phase Generator

This block sets the timing of the serial clock for an I2C master. It works from the peripheral clock and takes two programmable counts, one for the low part of the SCL period and one for the high part. Each count is scaled by eight peripheral clocks. The low and high halves can therefore differ, and software sets the duty cycle. A full period is `8 * ((low + 1) + (high + 1))` peripheral clocks. When both counts are zero, the period is 16 clocks. A driver that wants an odd total of units gives the extra unit to the high count.

The bit engine uses the block's outputs to pace SDA changes and SDA sampling. Two level outputs mark the low phase and the high phase. Two one-cycle strobes mark the last cycle before SCL rises and the last cycle before SCL falls. A separate output pulls SCL low during the low phase; at all other times SCL is released. The block runs only while its enable input is high. When enable drops, the block returns to idle, SCL is released and the counter clears. A slave may stretch the clock. If the sensed SCL line is low during the high phase, the high-phase count pauses until the line reads high.

All pins are plain control and status pins. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `scl_timing_gen`

## Requirements
- R1: While reset is asserted, and while enable is low after reset, the SCL pull-low output, both phase outputs and both strobes are 0.
- R2: After enable is seen high, the low phase begins on the next cycle. It lasts exactly 8*(low count+1) cycles, and the SCL pull-low output is 1 for all of them.
- R3: The high phase directly follows the low phase. Without stretching, it lasts exactly 8*(high count+1) cycles, with SCL released. The next low phase starts right after it.
- R4: The rise strobe is 1 only in the final cycle of each low phase. The fall strobe is 1 only in the final cycle of each high phase.
- R5: No rise strobe occurs in the high phase, and no fall strobe occurs in the low phase.
- R6: With both counts at 0, the full period is 16 cycles: 8 low and 8 high.
- R7: Each cycle of the high phase in which the sensed SCL line is 0 adds one cycle to that high phase. No fall strobe is raised while the line is held low.
- R8: Enable going low at any point makes every output 0 on the next cycle. A later enable starts again with a complete low phase.
- R9: The low and high counts are captured at the start of each period. A change made during a period takes effect only from the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Controller enable; low holds the block idle |
| low_cnt_i | input | DIV_W | Low-phase count; the phase lasts 8*(value+1) clocks |
| high_cnt_i | input | DIV_W | High-phase count; the phase lasts 8*(value+1) clocks |
| scl_sense_i | input | 1 | Sensed (already synchronized) level of the SCL line |
| scl_pull_low_o | output | 1 | 1 drives SCL low; 0 releases it |
| low_phase_o | output | 1 | 1 during the low phase |
| high_phase_o | output | 1 | 1 during the high phase |
| rise_stb_o | output | 1 | One-cycle strobe in the last cycle before SCL release |
| fall_stb_o | output | 1 | One-cycle strobe in the last cycle before SCL is pulled low |

## Verification
The bench measures whole periods for several count pairs. These include the all-zero minimum and strongly asymmetric settings, so an off-by-one in the eight-clock scaling or an exchanged low/high count appears as a wrong phase length. A slave hold is inserted in the middle of a high phase. A timer that ignored the line would end the phase early and strobe a fall while SCL is held low. One test changes the low count in the middle of a period. A design that reads the count live would shorten or stretch the phase already running, instead of waiting for the next period. Another test drops enable halfway through a low phase. A design that keeps its count across the drop would then produce a short first low phase after re-enable.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

  // Every count unit stands for 2**PRESCALE_BITS peripheral clocks.
  localparam int PRESCALE_BITS = 3;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;

endpackage

// File: rtl/scl_phase_timer.sv
module scl_phase_timer
  import scl_timing_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             hold_i,
  input  logic [DIV_W-1:0] limit_i,
  output logic             last_o
);

  localparam int CNT_W = DIV_W + PRESCALE_BITS;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term;

  // The terminal value is the count unit with all prescale bits set. The
  // result is 8*(limit+1) cycles per phase, and no separate prescaler is needed.
  assign term   = {limit_i, {PRESCALE_BITS{1'b1}}};
  assign last_o = (cnt_q == term);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clear_i)    cnt_q <= '0;
    else if (!hold_i)    cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end

  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !clear_i) |=> $stable(cnt_q)); // R7

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |-> (cnt_q <= term)); // R2

endmodule

// File: rtl/scl_field_hold.sv
module scl_field_hold #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DIV_W-1:0] low_i,
  input  logic [DIV_W-1:0] high_i,
  output logic [DIV_W-1:0] low_o,
  output logic [DIV_W-1:0] high_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_o  <= '0;
      high_o <= '0;
    end else if (load_i) begin
      low_o  <= low_i;
      high_o <= high_i;
    end
  end

  AST_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(low_o) && $stable(high_o))); // R9

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_timing_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic [DIV_W-1:0] low_cnt_i,
  input  logic [DIV_W-1:0] high_cnt_i,
  input  logic             scl_sense_i,
  output logic             scl_pull_low_o,
  output logic             low_phase_o,
  output logic             high_phase_o,
  output logic             rise_stb_o,
  output logic             fall_stb_o
);

  scl_phase_e       ph_q, ph_d;
  logic [DIV_W-1:0] low_q, high_q, limit;
  logic             t_last, t_clear, stretch, period_start;

  // A slave holds SCL low during the high phase: the count pauses.
  assign stretch = (ph_q == PH_HIGH) && !scl_sense_i;

  // A new period starts on entry to the low phase, either from idle or at the end of a high phase.
  assign period_start = enable_i &&
                        ((ph_q == PH_IDLE) ||
                         ((ph_q == PH_HIGH) && t_last && !stretch));

  assign limit   = (ph_q == PH_HIGH) ? high_q : low_q;
  assign t_clear = !enable_i || (ph_q == PH_IDLE);

  scl_field_hold #(.DIV_W(DIV_W)) u_fields (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (period_start),
    .low_i  (low_cnt_i),
    .high_i (high_cnt_i),
    .low_o  (low_q),
    .high_o (high_q)
  );

  scl_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (t_clear),
    .hold_i  (stretch),
    .limit_i (limit),
    .last_o  (t_last)
  );

  always_comb begin
    ph_d = ph_q;
    if (!enable_i) begin
      ph_d = PH_IDLE;
    end else begin
      unique case (ph_q)
        PH_IDLE: ph_d = PH_LOW;
        PH_LOW:  if (t_last) ph_d = PH_HIGH;
        PH_HIGH: if (t_last && !stretch) ph_d = PH_LOW;
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  assign scl_pull_low_o = (ph_q == PH_LOW);
  assign low_phase_o    = (ph_q == PH_LOW);
  assign high_phase_o   = (ph_q == PH_HIGH);
  assign rise_stb_o     = (ph_q == PH_LOW) && t_last;
  assign fall_stb_o     = (ph_q == PH_HIGH) && t_last && !stretch;

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (!scl_pull_low_o && !high_phase_o && !rise_stb_o && !fall_stb_o)); // R8

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && !low_phase_o && !high_phase_o) |=> scl_pull_low_o); // R2

  AST_RISE_TO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_stb_o && enable_i) |=> (high_phase_o && !scl_pull_low_o)); // R4

  AST_FALL_TO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_stb_o && enable_i) |=> scl_pull_low_o); // R4

  AST_STRETCH_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (high_phase_o && !scl_sense_i && enable_i) |=> high_phase_o); // R7

endmodule

// File: tb/scl_timing_gen_tb_top.sv
`timescale 1ns/1ps
module scl_timing_gen_tb_top;

  localparam int DIV_W = 8;
  // Each row holds the low count, the high count and the expected full period in clocks.
  localparam int VEC [6][3] = '{
    '{0, 0, 16}, '{1, 0, 24}, '{0, 1, 24},
    '{2, 5, 72}, '{7, 3, 96}, '{4, 4, 80}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n, enable, slave_hold;
  logic [DIV_W-1:0] low_cnt, high_cnt;
  logic             scl_sense, scl_pull_low, low_phase, high_phase, rise_stb, fall_stb;

  assign scl_sense = !scl_pull_low && !slave_hold;

  scl_timing_gen #(.DIV_W(DIV_W)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .enable_i       (enable),
    .low_cnt_i      (low_cnt),
    .high_cnt_i     (high_cnt),
    .scl_sense_i    (scl_sense),
    .scl_pull_low_o (scl_pull_low),
    .low_phase_o    (low_phase),
    .high_phase_o   (high_phase),
    .rise_stb_o     (rise_stb),
    .fall_stb_o     (fall_stb)
  );

  int checks = 0;
  int fails  = 0;
  int lo_len, hi_len, rise_at, fall_at, bad;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_idle(input string tag);
    check(tag, int'({scl_pull_low, low_phase, high_phase, rise_stb, fall_stb}), 0);
  endtask

  // Measures one low phase and the high phase after it. The task is entered at a negedge
  // and returns at the negedge whose sample is the first cycle of the next period.
  task automatic run_period(input int chg_at, input int chg_lo,
                            input int hs, input int hl);
    lo_len = 0; hi_len = 0; rise_at = -1; fall_at = -1; bad = 0;
    while (!low_phase) @(negedge clk);
    while (low_phase) begin
      lo_len++;
      if (rise_stb) rise_at = lo_len;
      if (fall_stb) bad++;
      if (lo_len == chg_at) low_cnt = DIV_W'(chg_lo);
      @(negedge clk);
    end
    while (high_phase) begin
      hi_len++;
      if (rise_stb) bad++;
      if (fall_stb) begin
        if (slave_hold) bad++;
        fall_at = hi_len;
      end
      if (hl > 0 && hi_len == hs)      slave_hold = 1'b1;
      if (hl > 0 && hi_len == hs + hl) slave_hold = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1-scope actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; enable = 1'b1; slave_hold = 1'b0;
    low_cnt = '0; high_cnt = '0;
    repeat (3) @(negedge clk);
    check_idle("R1 outputs in reset");
    enable = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R1 outputs while disabled");

    for (int v = 0; v < 6; v++) begin
      low_cnt  = DIV_W'(VEC[v][0]);
      high_cnt = DIV_W'(VEC[v][1]);
      enable   = 1'b1;
      for (int p = 0; p < 2; p++) begin
        run_period(0, 0, 0, 0);
        check("R2 low length",  lo_len, 8 * (VEC[v][0] + 1));
        check("R3 high length", hi_len, 8 * (VEC[v][1] + 1));
        check("R4 rise strobe position", rise_at, lo_len);
        check("R4 fall strobe position", fall_at, hi_len);
        check("R5 strobe in wrong phase", bad, 0);
        if (v == 0) check("R6 minimum period", lo_len + hi_len, VEC[v][2]);
        else        check("R3 full period", lo_len + hi_len, VEC[v][2]);
      end
      enable = 1'b0;
      @(negedge clk);
      check_idle("R8 idle after disable");
    end

    // R7: the slave holds SCL low for 5 cycles in the middle of the high phase.
    low_cnt = 8'd0; high_cnt = 8'd1; enable = 1'b1;
    run_period(0, 0, 3, 5);
    check("R7 stretched high length", hi_len, 21);
    check("R7 fall strobe after release", fall_at, 21);
    check("R7 no fall strobe while held", bad, 0);
    run_period(0, 0, 0, 0);
    check("R7 next high unstretched", hi_len, 16);
    enable = 1'b0;
    @(negedge clk);

    // R9: the low count changes in the middle of a period.
    low_cnt = 8'd1; high_cnt = 8'd0; enable = 1'b1;
    run_period(4, 3, 0, 0);
    check("R9 running low phase unchanged", lo_len, 16);
    run_period(0, 0, 0, 0);
    check("R9 new low count next period", lo_len, 32);
    enable = 1'b0;
    @(negedge clk);

    // R8: enable drops halfway through a low phase.
    low_cnt = 8'd3; high_cnt = 8'd2; enable = 1'b1;
    while (!low_phase) @(negedge clk);
    repeat (5) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check_idle("R8 idle after mid-phase disable");
    enable = 1'b1;
    run_period(0, 0, 0, 0);
    check("R8 full low phase after re-enable", lo_len, 32);
    check("R8 full high phase after re-enable", hi_len, 24);
    enable = 1'b0;
    @(negedge clk);

    finish_run();
  end

endmodule